// File: doc/BRIEF.md
# Linked-Script Power Sequencer

This block replays short power scripts held in a private instruction store whenever a power event arrives. Each instruction is four bytes: a 16-bit message for the power-resource bus, a wait count in slow-clock ticks, and the index of the instruction to run next. Execution follows these links rather than a program counter, so scripts can sit anywhere in the store and share tails. An all-ones index ends a script.

Software reaches the block through a small register port. It sets a byte address and then writes or reads a data register to fill the store. It also programs one start index for each of four events: entering sleep, waking processor groups one and two, waking group three, and warm reset. Every configuration write is refused until a two-key unlock sequence has been written to the key register. Events that arrive while a script runs are queued and served in a fixed priority order. A runaway chain is stopped after a set number of steps.

The message-bus receivers are outside the block. The slow clock reaches it as a one-cycle `slow_tick` strobe in the system clock domain.

Top module: `pwr_seq_engine`

## Requirements
- R1: The instruction at index i occupies store bytes 4i to 4i+3. Byte 4i is the message high byte and byte 4i+1 the low byte, so `msg_data` = {byte 4i, byte 4i+1}. Byte 4i+2 is the delay and the low six bits of byte 4i+3 are the next index.
- R2: Writing register 1 sets the store byte address. Writing register 2 stores the byte at that address, and reading register 2 returns the byte at that address.
- R3: The key register (register 0) opens configuration when the value 0xA5 is written and the very next key write is 0x5A. Any other second value returns it to locked. Writing 0 relocks it from any state. Reading register 0 returns 1 when open and 0 otherwise. While locked, writes to registers 1 to 6 have no effect.
- R4: The start indices sit at register 3 (sleep), 4 (wake groups 1/2), 5 (wake group 3) and 6 (warm reset). All four reset to 0x3F, and each event starts its script at its own index.
- R5: Index 0x3F ends a script. When the start index is 0x3F the event emits no message, never raises `busy` and gives no `done`. When an instruction's next index is 0x3F, `done` pulses for one cycle in the cycle the wait ends, with `busy` low.
- R6: After an instruction with delay d>0 is emitted, the next message appears 2 cycles after the d-th `slow_tick` sampled after the emission edge. With d=0 it appears 2 cycles after the previous one.
- R7: An event sampled at clock edge k produces its first message at edge k+2 when the engine is idle. `msg_valid` is high for exactly one cycle per instruction.
- R8: `busy` is high from edge k+1 after an accepted event until the script ends, and every message is emitted while `busy` is high.
- R9: Events that arrive during a script are held and run after it ends, in the order warm reset, wake 1/2, wake 3, sleep. Repeats of a pending event merge into one run.
- R10: If a script would go past its 64th emitted instruction without reaching 0x3F, `err` pulses for one cycle instead of `done` and the engine returns to idle after exactly 64 messages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| ev_sleep | input | 1 | Active-to-sleep event pulse |
| ev_wake12 | input | 1 | Sleep-to-active event, groups 1 and 2 |
| ev_wake3 | input | 1 | Sleep-to-active event, group 3 |
| ev_warm | input | 1 | Warm reset event pulse |
| slow_tick | input | 1 | One-cycle strobe per slow-clock period |
| msg_valid | output | 1 | Bus message strobe |
| msg_data | output | 16 | Bus message |
| busy | output | 1 | Script in progress |
| done | output | 1 | One-cycle end-of-script pulse |
| err | output | 1 | One-cycle chain-limit pulse |

## Verification
A wrong link, delay or byte lane inside the walker shows at the ports within one instruction. The message value differs, or its emission cycle moves away from the arithmetic tick schedule, so checking every message's cycle exposes an off-by-one in the wait counter at the first non-zero delay. A broken pending queue or priority shows in the order of the scripts' first messages once the running script ends. A broken lock shows at once, because the pointer readback reveals the change on the next read.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
   localparam int NUM_EV   = 4;
   localparam int RA_KEY   = 0;
   localparam int RA_MADDR = 1;
   localparam int RA_MDATA = 2;
   localparam int RA_PTR0  = 3;

   typedef enum logic [1:0] {
      EV_SLEEP  = 2'd0,
      EV_WAKE12 = 2'd1,
      EV_WAKE3  = 2'd2,
      EV_WARM   = 2'd3
   } ev_e;

   typedef enum logic [1:0] {
      KS_LOCKED = 2'd0,
      KS_HALF   = 2'd1,
      KS_OPEN   = 2'd2
   } key_state_e;

   typedef enum logic [1:0] {
      WS_IDLE  = 2'd0,
      WS_FETCH = 2'd1,
      WS_WAIT  = 2'd2
   } walk_state_e;
endpackage

// File: rtl/pseq_cfg_regs.sv
module pseq_cfg_regs
   import pwr_seq_pkg::*;
#(
   parameter int          IDX_W = 6,
   parameter int          RA_W  = 4,
   parameter logic [7:0]  KEY_A = 8'hA5,
   parameter logic [7:0]  KEY_B = 8'h5A
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [RA_W-1:0]                 addr,
   input  logic [7:0]                      wdata,
   output logic [7:0]                      rdata,
   output logic                            mem_we,
   output logic [IDX_W+1:0]                mem_addr,
   output logic [7:0]                      mem_wdata,
   input  logic [7:0]                      mem_rbyte,
   output logic [NUM_EV-1:0][IDX_W-1:0]    start_ptr,
   output logic                            cfg_open
);
   localparam logic [IDX_W-1:0] END_IDX = '1;

   key_state_e ks;
   logic       key_wr;
   logic       cfg_wr;

   assign key_wr = wr_en && (addr == RA_W'(RA_KEY));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ks <= KS_LOCKED;
      end else if (key_wr) begin
         if (wdata == 8'h00) begin
            ks <= KS_LOCKED;
         end else begin
            case (ks)
               KS_LOCKED: ks <= (wdata == KEY_A) ? KS_HALF : KS_LOCKED;
               KS_HALF:   ks <= (wdata == KEY_B) ? KS_OPEN : KS_LOCKED;
               KS_OPEN:   ks <= KS_OPEN;
               default:   ks <= KS_LOCKED;
            endcase
         end
      end
   end

   assign cfg_open  = (ks == KS_OPEN);
   assign cfg_wr    = wr_en && cfg_open;
   assign mem_we    = cfg_wr && (addr == RA_W'(RA_MDATA));
   assign mem_wdata = wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr <= '0;
      end else if (cfg_wr && (addr == RA_W'(RA_MADDR))) begin
         mem_addr <= wdata[IDX_W+1:0];
      end
   end

   for (genvar e = 0; e < NUM_EV; e++) begin : g_ptr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            start_ptr[e] <= END_IDX;
         end else if (cfg_wr && (addr == RA_W'(RA_PTR0 + e))) begin
            start_ptr[e] <= wdata[IDX_W-1:0];
         end
      end
   end

   always_comb begin
      rdata = 8'h00;
      if (addr == RA_W'(RA_KEY))   rdata = {7'd0, cfg_open};
      if (addr == RA_W'(RA_MADDR)) rdata = 8'(mem_addr);
      if (addr == RA_W'(RA_MDATA)) rdata = mem_rbyte;
      for (int e = 0; e < NUM_EV; e++) begin
         if (addr == RA_W'(RA_PTR0 + e)) rdata = 8'(start_ptr[e]);
      end
   end
endmodule

// File: rtl/pseq_imem.sv
module pseq_imem #(
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             we,
   input  logic [IDX_W+1:0] waddr,
   input  logic [7:0]       wdata,
   output logic [7:0]       rbyte,
   input  logic [IDX_W-1:0] fetch_idx,
   output logic [15:0]      f_msg,
   output logic [7:0]       f_dly,
   output logic [IDX_W-1:0] f_nxt
);
   localparam int AB    = IDX_W + 2;
   localparam int DEPTH = 1 << AB;
   localparam int LANES = 3;

   logic [7:0] mem [DEPTH];
   logic [7:0] lane [LANES];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rbyte = mem[waddr];

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane[l] = mem[{fetch_idx, 2'(l)}];
   end

   assign f_msg = {lane[0], lane[1]};
   assign f_dly = lane[2];
   assign f_nxt = mem[{fetch_idx, 2'd3}][IDX_W-1:0];
endmodule

// File: rtl/pseq_walker.sv
module pseq_walker
   import pwr_seq_pkg::*;
#(
   parameter int IDX_W     = 6,
   parameter int HOP_LIMIT = 64
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_EV-1:0]             ev_in,
   input  logic [NUM_EV-1:0][IDX_W-1:0]  start_ptr,
   input  logic                          slow_tick,
   output logic [IDX_W-1:0]              fetch_idx,
   input  logic [15:0]                   f_msg,
   input  logic [7:0]                    f_dly,
   input  logic [IDX_W-1:0]              f_nxt,
   output logic                          msg_valid,
   output logic [15:0]                   msg_data,
   output logic                          busy,
   output logic                          done,
   output logic                          err
);
   localparam logic [IDX_W-1:0] END_IDX = '1;
   localparam int               HOP_W   = $clog2(HOP_LIMIT + 1);
   localparam ev_e              PRIO [NUM_EV] = '{EV_WARM, EV_WAKE12, EV_WAKE3, EV_SLEEP};

   walk_state_e       state;
   logic [NUM_EV-1:0] pend;
   logic [NUM_EV-1:0] pend_clr;
   logic              sel_valid;
   ev_e               sel_ev;
   logic [IDX_W-1:0]  cur_idx;
   logic [IDX_W-1:0]  nxt_q;
   logic [7:0]        dly_q;
   logic [7:0]        cnt;
   logic [HOP_W-1:0]  hops;

   always_comb begin
      sel_valid = 1'b0;
      sel_ev    = EV_SLEEP;
      for (int i = NUM_EV - 1; i >= 0; i--) begin
         if (pend[PRIO[i]]) begin
            sel_valid = 1'b1;
            sel_ev    = PRIO[i];
         end
      end
      pend_clr = '0;
      if (state == WS_IDLE && sel_valid) pend_clr[sel_ev] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= WS_IDLE;
         pend      <= '0;
         cur_idx   <= '0;
         nxt_q     <= '0;
         dly_q     <= '0;
         cnt       <= '0;
         hops      <= '0;
         msg_valid <= 1'b0;
         msg_data  <= '0;
         done      <= 1'b0;
         err       <= 1'b0;
      end else begin
         msg_valid <= 1'b0;
         done      <= 1'b0;
         err       <= 1'b0;
         pend      <= (pend & ~pend_clr) | ev_in;
         case (state)
            WS_IDLE: begin
               if (sel_valid && start_ptr[sel_ev] != END_IDX) begin
                  cur_idx <= start_ptr[sel_ev];
                  hops    <= '0;
                  state   <= WS_FETCH;
               end
            end
            WS_FETCH: begin
               msg_valid <= 1'b1;
               msg_data  <= f_msg;
               dly_q     <= f_dly;
               nxt_q     <= f_nxt;
               cnt       <= '0;
               hops      <= hops + 1'b1;
               state     <= WS_WAIT;
            end
            WS_WAIT: begin
               if (cnt == dly_q) begin
                  if (nxt_q == END_IDX) begin
                     done  <= 1'b1;
                     state <= WS_IDLE;
                  end else if (hops == HOP_W'(HOP_LIMIT)) begin
                     err   <= 1'b1;
                     state <= WS_IDLE;
                  end else begin
                     cur_idx <= nxt_q;
                     state   <= WS_FETCH;
                  end
               end else if (slow_tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= WS_IDLE;
         endcase
      end
   end

   assign fetch_idx = cur_idx;
   assign busy      = (state != WS_IDLE);
endmodule

// File: rtl/pwr_seq_engine.sv
module pwr_seq_engine
   import pwr_seq_pkg::*;
#(
   parameter int          IDX_W     = 6,
   parameter int          HOP_LIMIT = 64,
   parameter int          RA_W      = 4,
   parameter logic [7:0]  KEY_A     = 8'hA5,
   parameter logic [7:0]  KEY_B     = 8'h5A
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_wr,
   input  logic [RA_W-1:0] reg_addr,
   input  logic [7:0]      reg_wdata,
   output logic [7:0]      reg_rdata,
   input  logic            ev_sleep,
   input  logic            ev_wake12,
   input  logic            ev_wake3,
   input  logic            ev_warm,
   input  logic            slow_tick,
   output logic            msg_valid,
   output logic [15:0]     msg_data,
   output logic            busy,
   output logic            done,
   output logic            err
);
   if (IDX_W < 2 || IDX_W > 6) begin : g_bad_idx
      $error("IDX_W must lie in 2..6 so a byte address fits one register");
   end
   if (HOP_LIMIT < 1) begin : g_bad_hop
      $error("HOP_LIMIT must be positive");
   end
   if (KEY_A == 8'h00 || KEY_B == 8'h00 || KEY_A == KEY_B) begin : g_bad_key
      $error("unlock keys must be distinct and non-zero");
   end
   if (RA_W < 3) begin : g_bad_ra
      $error("RA_W must address at least seven registers");
   end

   logic                          mem_we;
   logic [IDX_W+1:0]              mem_addr;
   logic [7:0]                    mem_wdata;
   logic [7:0]                    mem_rbyte;
   logic [NUM_EV-1:0][IDX_W-1:0]  start_ptr;
   logic                          cfg_open;
   logic [IDX_W-1:0]              fetch_idx;
   logic [15:0]                   f_msg;
   logic [7:0]                    f_dly;
   logic [IDX_W-1:0]              f_nxt;
   logic [NUM_EV-1:0]             ev_vec;

   always_comb begin
      ev_vec            = '0;
      ev_vec[EV_SLEEP]  = ev_sleep;
      ev_vec[EV_WAKE12] = ev_wake12;
      ev_vec[EV_WAKE3]  = ev_wake3;
      ev_vec[EV_WARM]   = ev_warm;
   end

   pseq_cfg_regs #(
      .IDX_W (IDX_W),
      .RA_W  (RA_W),
      .KEY_A (KEY_A),
      .KEY_B (KEY_B)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .rdata     (reg_rdata),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rbyte (mem_rbyte),
      .start_ptr (start_ptr),
      .cfg_open  (cfg_open)
   );

   pseq_imem #(
      .IDX_W (IDX_W)
   ) u_imem (
      .clk       (clk),
      .we        (mem_we),
      .waddr     (mem_addr),
      .wdata     (mem_wdata),
      .rbyte     (mem_rbyte),
      .fetch_idx (fetch_idx),
      .f_msg     (f_msg),
      .f_dly     (f_dly),
      .f_nxt     (f_nxt)
   );

   pseq_walker #(
      .IDX_W     (IDX_W),
      .HOP_LIMIT (HOP_LIMIT)
   ) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_in     (ev_vec),
      .start_ptr (start_ptr),
      .slow_tick (slow_tick),
      .fetch_idx (fetch_idx),
      .f_msg     (f_msg),
      .f_dly     (f_dly),
      .f_nxt     (f_nxt),
      .msg_valid (msg_valid),
      .msg_data  (msg_data),
      .busy      (busy),
      .done      (done),
      .err       (err)
   );
endmodule

// File: rtl/pwr_seq_engine_chk.sv
module pwr_seq_engine_chk
   import pwr_seq_pkg::*;
#(
   parameter int IDX_W = 6
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          msg_valid,
   input logic                          busy,
   input logic                          done,
   input logic                          err,
   input logic                          cfg_open,
   input logic [NUM_EV-1:0][IDX_W-1:0]  start_ptr
);
   // R7: each message strobe lasts a single cycle
   p_msg_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |=> !msg_valid);

   // R8: messages only leave while a script is in progress
   p_msg_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> busy);

   // R5: end of script is reported with the engine already idle
   p_end_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done || err) |-> !busy);

   // R5: no message in the cycle right after a script ends
   p_end_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done || err) |=> !msg_valid);

   // R10: message, done and chain error never coincide
   p_out_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, err, msg_valid}));

   // R3: start indices cannot move while configuration is locked
   p_lock_ptr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_open |=> $stable(start_ptr));
endmodule

bind pwr_seq_engine pwr_seq_engine_chk #(.IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .msg_valid (msg_valid),
   .busy      (busy),
   .done      (done),
   .err       (err),
   .cfg_open  (cfg_open),
   .start_ptr (start_ptr)
);

// File: tb/pwr_seq_engine_bench.sv
module pwr_seq_engine_bench;
   localparam int P     = 8;
   localparam int NLOG  = 1024;
   localparam int ENDIX = 63;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [3:0]  ev = '0;
   logic        slow_tick = 1'b0;
   logic        msg_valid, busy, done, err;
   logic [15:0] msg_data;

   int cyc = 0;
   int checks = 0;
   int fails = 0;
   int mcount = 0;
   int done_count = 0;
   int done_cyc = 0;
   int err_count = 0;
   int busy_seen = 0;
   int mlog_cyc [NLOG];
   logic [15:0] mlog_data [NLOG];

   always #10 clk = ~clk;

   pwr_seq_engine u_pwr_seq_engine (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ev_sleep(ev[0]), .ev_wake12(ev[1]), .ev_wake3(ev[2]), .ev_warm(ev[3]),
      .slow_tick(slow_tick), .msg_valid(msg_valid), .msg_data(msg_data),
      .busy(busy), .done(done), .err(err)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (msg_valid && mcount < NLOG) begin
         mlog_data[mcount] = msg_data;
         mlog_cyc[mcount]  = cyc;
         mcount++;
      end
      if (done) begin
         done_cyc = cyc;
         done_count++;
      end
      if (err) err_count++;
      if (busy) busy_seen++;
      slow_tick = ((cyc + 1) % P == 0);
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (cyc == 150000) begin
         fails++;
         $display("FAIL R8 watchdog actual=%0d expected=%0d", cyc, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk);
      reg_addr = 4'(a);
      #1 d = int'(reg_rdata);
   endtask

   task automatic fire(input int mask, output int k);
      @(negedge clk);
      ev = 4'(mask);
      k = cyc + 1;
      @(negedge clk);
      ev = '0;
   endtask

   task automatic wait_done(input int target, input string req);
      int t = 0;
      while (done_count < target && t < 4000) begin
         @(negedge clk);
         t++;
      end
      chk(done_count >= target, req, done_count, target);
   endtask

   function automatic int idx_of(input int e, input int j);
      return (e % 2 == 0) ? 1 + e * 12 + j * 2 : 1 + e * 12 + (4 - j) * 2;
   endfunction
   function automatic int msg_of(input int e, input int j);
      return ((e + 1) * 16'h1000 + j * 16'h0101 + e * 3) & 16'hFFFF;
   endfunction
   function automatic int dly_of(input int e, input int j);
      return (j * 3 + e) % 5;
   endfunction
   function automatic int tick_after(input int x, input int d);
      return (x / P + 1) * P + (d - 1) * P;
   endfunction

   task automatic load_ins(input int idx, input int msg, input int dly, input int nxt);
      wr(1, idx * 4);     wr(2, (msg >> 8) & 255);
      wr(1, idx * 4 + 1); wr(2, msg & 255);
      wr(1, idx * 4 + 2); wr(2, dly);
      wr(1, idx * 4 + 3); wr(2, nxt);
   endtask

   task automatic run_check(input int e);
      int base, d0, k, expc, t, d, exp_done;
      base = mcount;
      d0 = done_count;
      fire(1 << e, k);
      @(negedge clk);
      chk(busy == 1'b1, "R8 busy after event", int'(busy), 1);
      wait_done(d0 + 1, "R5 script end");
      chk(busy == 1'b0, "R8 idle at end", int'(busy), 0);
      chk(mcount - base == 5, "R1 message count", mcount - base, 5);
      expc = k + 2;
      exp_done = 0;
      for (int j = 0; j < 5; j++) begin
         chk(mlog_data[base + j] == 16'(msg_of(e, j)), "R1 R4 message value",
             int'(mlog_data[base + j]), msg_of(e, j));
         chk(mlog_cyc[base + j] == expc, (j == 0) ? "R7 first latency" : "R6 delay spacing",
             mlog_cyc[base + j], expc);
         d = dly_of(e, j);
         t = (d == 0) ? expc : tick_after(expc, d);
         if (j < 4) expc = t + 2;
         else exp_done = t + 1;
      end
      chk(done_cyc == exp_done, "R5 done timing", done_cyc, exp_done);
   endtask

   initial begin
      int v, k, base, d0, e0;
      int order [5];
      order = '{0, 3, 1, 2, 0};
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      for (int a = 3; a < 7; a++) begin
         rd(a, v);
         chk(v == 63, "R4 reset start index", v, 63);
      end
      rd(0, v); chk(v == 0, "R3 reset locked", v, 0);
      rd(1, v); chk(v == 0, "R2 reset address", v, 0);
      chk(busy == 0 && msg_valid == 0 && done == 0 && err == 0, "R8 reset outputs",
          int'({busy, msg_valid, done, err}), 0);

      // lock behaviour
      wr(3, 5); rd(3, v); chk(v == 63, "R3 locked write ignored", v, 63);
      wr(0, 8'hA5); wr(0, 8'h33); rd(0, v); chk(v == 0, "R3 wrong second key", v, 0);
      wr(3, 5); rd(3, v); chk(v == 63, "R3 still locked", v, 63);
      wr(0, 8'h5A); wr(0, 8'hA5); rd(0, v); chk(v == 0, "R3 key order", v, 0);
      wr(0, 8'h5A); rd(0, v); chk(v == 1, "R3 unlocked", v, 1);
      wr(3, 5); rd(3, v); chk(v == 5, "R3 open write", v, 5);
      wr(0, 8'h77); rd(0, v); chk(v == 1, "R3 stays open", v, 1);
      wr(0, 0); rd(0, v); chk(v == 0, "R3 relock", v, 0);
      wr(3, 7); rd(3, v); chk(v == 5, "R3 relocked write ignored", v, 5);
      wr(0, 8'hA5); wr(0, 8'h5A);

      // store sweep
      for (int a = 0; a < 256; a++) begin
         wr(1, a); wr(2, (a * 7 + 3) & 255);
      end
      for (int a = 0; a < 256; a++) begin
         wr(1, a); rd(2, v);
         chk(v == ((a * 7 + 3) & 255), "R2 store readback", v, (a * 7 + 3) & 255);
      end
      rd(1, v); chk(v == 255, "R2 address readback", v, 255);

      // locked store write has no effect
      wr(0, 0); wr(2, 8'h00); rd(2, v);
      chk(v == ((255 * 7 + 3) & 255), "R3 locked store write", v, (255 * 7 + 3) & 255);
      wr(0, 8'hA5); wr(0, 8'h5A);

      // four scripts
      for (int e = 0; e < 4; e++) begin
         for (int j = 0; j < 5; j++)
            load_ins(idx_of(e, j), msg_of(e, j), dly_of(e, j), (j == 4) ? ENDIX : idx_of(e, j + 1));
         wr(3 + e, idx_of(e, 0));
      end
      for (int e = 0; e < 4; e++) run_check(e);

      // start index at end marker
      wr(5, 63);
      base = mcount; v = busy_seen; d0 = done_count;
      fire(4, k);
      repeat (30) @(negedge clk);
      chk(mcount == base, "R5 empty script no message", mcount - base, 0);
      chk(busy_seen == v, "R5 empty script no busy", busy_seen - v, 0);
      chk(done_count == d0, "R5 empty script no done", done_count - d0, 0);
      wr(5, idx_of(2, 0));

      // pending and priority
      base = mcount; d0 = done_count;
      fire(1, k);
      repeat (3) @(negedge clk);
      fire(5, k);
      fire(2, k);
      fire(1, k);
      fire(8, k);
      wait_done(d0 + 5, "R9 queued scripts");
      repeat (20) @(negedge clk);
      chk(mcount - base == 25, "R9 queued message count", mcount - base, 25);
      for (int s = 0; s < 5; s++)
         chk(mlog_data[base + s * 5] == 16'(msg_of(order[s], 0)), "R9 priority order",
             int'(mlog_data[base + s * 5]), msg_of(order[s], 0));

      // runaway chain
      load_ins(50, 16'hBEEF, 0, 50);
      wr(6, 50);
      base = mcount; d0 = done_count; e0 = err_count;
      fire(8, k);
      for (int t = 0; t < 2000 && err_count == e0; t++) @(negedge clk);
      @(negedge clk);
      chk(err_count == e0 + 1, "R10 error pulse", err_count - e0, 1);
      chk(mcount - base == 64, "R10 message count", mcount - base, 64);
      chk(done_count == d0, "R10 no done", done_count - d0, 0);
      chk(busy == 0, "R10 idle after cut", int'(busy), 0);
      chk(mlog_data[base + 63] == 16'hBEEF, "R1 loop message", int'(mlog_data[base + 63]), 16'hBEEF);
      chk(mlog_cyc[base + 63] == k + 2 + 63 * 2, "R6 zero delay spacing",
          mlog_cyc[base + 63], k + 2 + 63 * 2);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule